// File: doc/BRIEF.md
# Microsecond PWM Generator with Single-Period Mode

This block produces a pulse-width modulated waveform whose high time and low time are programmed separately, each as a 16-bit count of microseconds. A host writes the two counts one byte at a time through a small write port. A prescaler, sized by a parameter that gives the number of clock cycles in one microsecond, turns the system clock into a microsecond tick. The phase counters advance on that tick.

A control write sets or clears the run bit. A level mode input picks one of two behaviours. In the first the waveform repeats for as long as the run bit is set. In the second the generator produces exactly one high-then-low period and then clears its own run bit. The run bit can be read back at all times, so the host can see when a single period has finished. Time values written while the generator runs are picked up at the next period boundary. A period that is already under way keeps its old values.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset the output is low, the run bit reads 0, and both times are zero, so enabling before any time write gives a constant low output.
- R2: `cfg_sel` selects the byte written: 0 = high-time low byte, 1 = high-time high byte, 2 = low-time low byte, 3 = low-time high byte. A write changes only the selected byte.
- R3: A control write with `ctl_run`=1 while stopped sets the run bit on that edge. From the next cycle the output is high for (high time × CLK_PER_US) cycles.
- R4: After the high phase the output is low for (low time × CLK_PER_US) cycles.
- R5: A high time of 1 and a low time of 1 give a square wave with a period of 2 µs and 50% duty.
- R6: With `ctl_oneshot`=0 the high/low period repeats while the run bit stays set.
- R7: With `ctl_oneshot`=1 at the end of a period, the run bit clears on the edge that ends the period, and the output then stays low. The period lasts max(high+low, 1) µs.
- R8: Time writes made during a period do not change that period. They take effect from the next period start.
- R9: A high time of 0 gives a constant low output. A nonzero high time with a low time of 0 gives a constant high output.
- R10: A control write with `ctl_run`=0 clears the run bit and forces the output low from the next cycle.
- R11: A control write with `ctl_run`=1 while already running does not restart or disturb the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Time byte write strobe |
| cfg_sel | input | 2 | Time byte select (see R2) |
| cfg_wdata | input | 8 | Time byte value |
| ctl_we | input | 1 | Run bit write strobe |
| ctl_run | input | 1 | Value written to the run bit |
| ctl_oneshot | input | 1 | 1 = single period, 0 = continuous |
| pwm_out | output | 1 | PWM waveform |
| run_status | output | 1 | Readback of the run bit |

## Verification
A sweep runs every pair of high and low times from 0 to 3 µs in both modes. Each output sample is compared against a waveform computed arithmetically in the bench. This sweep separates the zero-length phase cases, the fastest square wave and the one-shot self-clear timing.

Times with a nonzero high byte show whether bytes are assembled into the correct half of the count. A rewrite of only the low byte shows that the other byte is left alone. A mid-period reprogramming shows that the new values wait for the period boundary. A redundant run write and a mid-phase stop show how control writes act on a running waveform.

// File: rtl/pwm_burst_pkg.sv
// Shared types for the microsecond PWM generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pwm_burst_pkg;

    // Sequencer phases: stopped, driving high, driving low, running with zero-length period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

endpackage

// File: rtl/pwm_us_tick.sv
// Microsecond tick prescaler.
// Emits a one-cycle tick every CLK_PER_US cycles while 'active' is high.
// Held at zero while inactive, so the first tick after starting arrives
// exactly CLK_PER_US cycles after the start edge.
module pwm_us_tick #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_US - 1);

    logic [CNT_W-1:0] div_q;

    // Divide the clock down to one count per microsecond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!active || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = active && (div_q == LAST);

endmodule

// File: rtl/pwm_time_regs.sv
// Byte-wise holding registers for the high and low times.
// Select values 0..NB-1 address the high-time bytes (least significant
// first), NB..2*NB-1 the low-time bytes. Assumes TIME_W is a multiple of BYTE_W.
module pwm_time_regs #(
    parameter int TIME_W = 16,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [TIME_W-1:0] hi_time,
    output logic [TIME_W-1:0] lo_time
);
    localparam int NB = TIME_W / BYTE_W;

    logic [BYTE_W-1:0] byte_q [2*NB];

    for (genvar g = 0; g < 2*NB; g++) begin : g_byte
        // Load one byte when its select value is written
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[g] <= '0;
            end else if (we && sel == SEL_W'(g)) begin
                byte_q[g] <= wdata;
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_pack
        assign hi_time[b*BYTE_W +: BYTE_W] = byte_q[b];
        assign lo_time[b*BYTE_W +: BYTE_W] = byte_q[NB + b];
    end

endmodule

// File: rtl/pwm_phase_seq.sv
// Phase sequencer: owns the run bit, the phase state and the tick counter.
// Times are sampled at each period start. High and low phases last their
// count in ticks. A zero-length period (both times zero) ends at the next
// tick. At period end, single-period mode clears the run bit.
module pwm_phase_seq
    import pwm_burst_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctl_we,
    input  logic              ctl_run,
    input  logic              ctl_oneshot,
    input  logic [TIME_W-1:0] hi_time,
    input  logic [TIME_W-1:0] lo_time,
    output logic              pwm_out,
    output logic              run_q
);
    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    phase_e            phase_q, phase_n;
    logic [TIME_W-1:0] cnt_q, cnt_n;
    logic [TIME_W-1:0] lo_act_q, lo_act_n;
    logic              run_n;

    phase_e            st_phase;
    logic [TIME_W-1:0] st_cnt;
    logic              last_tick;

    // First phase of a fresh period, taken from the holding registers
    always_comb begin
        if (hi_time != '0) begin
            st_phase = PH_HIGH;
            st_cnt   = hi_time;
        end else if (lo_time != '0) begin
            st_phase = PH_LOW;
            st_cnt   = lo_time;
        end else begin
            st_phase = PH_HOLD;
            st_cnt   = '0;
        end
    end

    assign last_tick = tick && (cnt_q == ONE);

    // Next-state decision for run bit, phase, counter and latched low time
    always_comb begin
        run_n    = run_q;
        phase_n  = phase_q;
        cnt_n    = cnt_q;
        lo_act_n = lo_act_q;
        if (ctl_we && !ctl_run) begin
            run_n   = 1'b0;
            phase_n = PH_IDLE;
            cnt_n   = '0;
        end else if (ctl_we && ctl_run && !run_q) begin
            run_n    = 1'b1;
            phase_n  = st_phase;
            cnt_n    = st_cnt;
            lo_act_n = lo_time;
        end else if (run_q && tick) begin
            if (phase_q == PH_HIGH && !last_tick) begin
                cnt_n = cnt_q - 1'b1;
            end else if (phase_q == PH_HIGH && lo_act_q != '0) begin
                phase_n = PH_LOW;
                cnt_n   = lo_act_q;
            end else if (phase_q == PH_LOW && !last_tick) begin
                cnt_n = cnt_q - 1'b1;
            end else if (ctl_oneshot) begin
                run_n   = 1'b0;
                phase_n = PH_IDLE;
                cnt_n   = '0;
            end else begin
                phase_n  = st_phase;
                cnt_n    = st_cnt;
                lo_act_n = lo_time;
            end
        end
    end

    // Register the sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            lo_act_q <= '0;
        end else begin
            run_q    <= run_n;
            phase_q  <= phase_n;
            cnt_q    <= cnt_n;
            lo_act_q <= lo_act_n;
        end
    end

    assign pwm_out = (phase_q == PH_HIGH);

endmodule

// File: rtl/pwm_burst_gen.sv
// Top of the microsecond PWM generator.
// Connects the time holding registers, the microsecond prescaler and the
// phase sequencer. Assumes CLK_PER_US >= 1 and TIME_W a multiple of BYTE_W.
module pwm_burst_gen #(
    parameter int CLK_PER_US = 125,
    parameter int TIME_W     = 16,
    parameter int BYTE_W     = 8,
    localparam int SEL_W     = $clog2(2 * (TIME_W / BYTE_W))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              ctl_we,
    input  logic              ctl_run,
    input  logic              ctl_oneshot,
    output logic              pwm_out,
    output logic              run_status
);
    logic [TIME_W-1:0] hi_time;
    logic [TIME_W-1:0] lo_time;
    logic              us_tick;
    logic              run_q;

    pwm_time_regs #(
        .TIME_W (TIME_W),
        .BYTE_W (BYTE_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .hi_time (hi_time),
        .lo_time (lo_time)
    );

    pwm_us_tick #(
        .CLK_PER_US (CLK_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (run_q),
        .tick   (us_tick)
    );

    pwm_phase_seq #(
        .TIME_W (TIME_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (us_tick),
        .ctl_we      (ctl_we),
        .ctl_run     (ctl_run),
        .ctl_oneshot (ctl_oneshot),
        .hi_time     (hi_time),
        .lo_time     (lo_time),
        .pwm_out     (pwm_out),
        .run_q       (run_q)
    );

    assign run_status = run_q;

endmodule

// File: rtl/pwm_burst_chk.sv
// Property checker for pwm_burst_gen, attached by bind below.
module pwm_burst_chk #(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              ctl_run,
    input logic              ctl_oneshot,
    input logic              tick,
    input logic [TIME_W-1:0] hi_time,
    input logic              pwm_out,
    input logic              run_status
);
    p_low_when_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_status |-> !pwm_out);

    p_stop_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_run) |=> (!run_status && !pwm_out));

    p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_run && !run_status && hi_time != '0) |=> (pwm_out && run_status));

    p_zero_high_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_run && !run_status && hi_time == '0) |=> !pwm_out);

    p_edge_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out != $past(pwm_out)) && !$past(ctl_we)) |-> $past(tick));

    p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run_status) && !$past(ctl_we)) |-> ($past(ctl_oneshot) && $past(tick)));

endmodule

bind pwm_burst_gen pwm_burst_chk #(.TIME_W(TIME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_run     (ctl_run),
    .ctl_oneshot (ctl_oneshot),
    .tick        (us_tick),
    .hi_time     (hi_time),
    .pwm_out     (pwm_out),
    .run_status  (run_status)
);

// File: tb/test_pwm_burst_gen.sv
// Self-checking bench: small prescaler, sweeps of times and modes.
module test_pwm_burst_gen;
    localparam int P = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       ctl_we = 1'b0;
    logic       ctl_run = 1'b0;
    logic       ctl_oneshot = 1'b0;
    logic       pwm_out;
    logic       run_status;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    pwm_burst_gen #(.CLK_PER_US(P), .TIME_W(16), .BYTE_W(8)) i_pwm_burst_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctl_we(ctl_we), .ctl_run(ctl_run),
        .ctl_oneshot(ctl_oneshot), .pwm_out(pwm_out), .run_status(run_status)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 8'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_times(input int hi, input int lo);
        wr_byte(0, hi & 255); wr_byte(1, hi >> 8);
        wr_byte(2, lo & 255); wr_byte(3, lo >> 8);
    endtask

    // Start write; returns at the first sample point (k = 0)
    task automatic start_run();
        @(negedge clk);
        ctl_we = 1'b1; ctl_run = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic stop_run();
        @(negedge clk);
        ctl_we = 1'b1; ctl_run = 1'b0;
        @(negedge clk);
        ctl_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic bit exp_wave(input int hi, input int lo, input int k);
        if (hi == 0) return 1'b0;
        if (lo == 0) return 1'b1;
        return (k % ((hi + lo) * P)) < hi * P;
    endfunction

    // One configuration; one check over all samples (R3/R4/R5/R6/R7/R9)
    task automatic sweep_one(input int hi, input int lo, input bit one);
        int len, n, miss, fk, fa, fe;
        bit e_out, e_run;
        string req;
        ctl_oneshot = one;
        set_times(hi, lo);
        len = ((hi + lo) > 0 ? (hi + lo) : 1) * P;
        n = 3 * len + 4;
        miss = 0; fk = -1; fa = 0; fe = 0;
        start_run();
        for (int k = 0; k < n; k++) begin
            e_run = one ? (k < len) : 1'b1;
            e_out = (one && k >= len) ? 1'b0 : exp_wave(hi, lo, k);
            if (pwm_out !== e_out || run_status !== e_run) begin
                if (fk < 0) begin
                    fk = k;
                    fa = int'(pwm_out) * 2 + int'(run_status);
                    fe = int'(e_out) * 2 + int'(e_run);
                end
                miss++;
            end
            @(negedge clk);
        end
        if (one) req = "R7";
        else if (hi == 1 && lo == 1) req = "R5";
        else if (hi == 0 || lo == 0) req = "R9";
        else req = "R3/R4/R6";
        if (miss != 0)
            $display("  config hi=%0d lo=%0d oneshot=%0d first bad sample k=%0d (out*2+run)", hi, lo, one, fk);
        check(miss == 0, req, fa, fe);
        stop_run();
    endtask

    // Count consecutive high cycles from the start sample
    task automatic measure_high(output int len);
        len = 0;
        while (pwm_out === 1'b1 && len < 2000) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin : main
        int len, miss8, miss11;
        bit e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(pwm_out === 1'b0, "R1 out after reset", int'(pwm_out), 0);
        check(run_status === 1'b0, "R1 run after reset", int'(run_status), 0);
        // R1: times reset to zero -> enabling gives constant low
        ctl_oneshot = 1'b0;
        start_run();
        miss8 = 0;
        for (int k = 0; k < 12; k++) begin
            if (pwm_out !== 1'b0 || run_status !== 1'b1) miss8++;
            @(negedge clk);
        end
        check(miss8 == 0, "R1 zero times constant low", miss8, 0);
        stop_run();

        // Sweep of small times in both modes
        for (int one = 0; one < 2; one++)
            for (int hi = 0; hi < 4; hi++)
                for (int lo = 0; lo < 4; lo++)
                    sweep_one(hi, lo, bit'(one));

        // R2: byte assembly, high byte lands in upper half
        ctl_oneshot = 1'b0;
        set_times(16'h0102, 1);
        start_run();
        measure_high(len);
        check(len == 258 * P, "R2 high time 0x0102", len, 258 * P);
        stop_run();
        // R2: low byte rewrite leaves high byte alone
        wr_byte(0, 0);
        start_run();
        measure_high(len);
        check(len == 256 * P, "R2 low byte only rewrite", len, 256 * P);
        stop_run();

        // R8 and R11: reprogram mid-period, redundant run write later
        set_times(2, 2);
        start_run();
        miss8 = 0; miss11 = 0;
        for (int k = 0; k < 40; k++) begin
            e = (k < 12) ? exp_wave(2, 2, k) : exp_wave(1, 3, k - 12);
            if (pwm_out !== e || run_status !== 1'b1) begin
                if (k < 20) miss8++; else miss11++;
            end
            if (k >= 2 && k <= 5) begin
                cfg_we = 1'b1;
                cfg_sel = 2'(k - 2);
                cfg_wdata = (k == 2) ? 8'd1 : (k == 4) ? 8'd3 : 8'd0;
            end else begin
                cfg_we = 1'b0;
            end
            ctl_run = 1'b1;
            ctl_we = (k == 20);
            @(negedge clk);
        end
        ctl_we = 1'b0;
        check(miss8 == 0, "R8 new times wait for period start", miss8, 0);
        check(miss11 == 0, "R11 run write while running ignored", miss11, 0);
        stop_run();

        // R10: stop during the high phase
        set_times(3, 1);
        start_run();
        repeat (4) @(negedge clk);
        check(pwm_out === 1'b1, "R10 high before stop", int'(pwm_out), 1);
        ctl_we = 1'b1; ctl_run = 1'b0;
        @(negedge clk);
        ctl_we = 1'b0;
        check(pwm_out === 1'b0, "R10 out low after stop", int'(pwm_out), 0);
        check(run_status === 1'b0, "R10 run cleared", int'(run_status), 0);
        miss8 = 0;
        for (int k = 0; k < 15; k++) begin
            if (pwm_out !== 1'b0) miss8++;
            @(negedge clk);
        end
        check(miss8 == 0, "R10 stays low while stopped", miss8, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule